// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Level and Threshold Flags

This block holds the audio words that pass between a processor-side port and a serial audio engine. It has two FIFOs of 16 words by 32 bits each. The playback queue is filled by the processor or a DMA engine and drained by the serializer. The capture queue is filled by the deserializer and drained by the processor or DMA. Each queue reports its fill level, full and empty state, and a threshold flag that follows the level from cycle to cycle. Each queue also has sticky error flags for overflow and underflow, cleared by a write-one strobe.

A flush strobe empties a queue at once. Every flag source passes through its own enable bit, and the enabled sources are merged into a capture summary, a playback summary and one combined interrupt line. The level output is only four bits wide, so a full queue and an empty queue both read as level 0. Software tells them apart from the full flag. The capture queue never stalls its writer: when it is full, the newest word replaces the oldest. The register decode and the serial engine sit outside this block.

Top module: `audio_fifo_flags`

## Requirements
- R1: Each queue stores up to 16 words of 32 bits and returns them in write order. The word at the head is visible on the read-data output in the same cycle as the pop. Full is high exactly when 16 words are held, and empty is high exactly when 0 words are held.
- R2: The level output carries the low 4 bits of the word count. It therefore reads 0 both when the queue is empty and when it holds 16 words, and the full flag separates the two cases.
- R3: The playback threshold flag is high while the playback word count is less than or equal to the 4-bit playback threshold input. It goes low in the cycle the count exceeds that value.
- R4: The capture threshold flag is high while the capture word count is at least the 4-bit capture threshold code plus one. Code 0 means 1 word and code 15 means 16 words.
- R5: A capture write into a full capture queue with no pop in the same cycle drops the oldest word, appends the new one, keeps the count at 16 and sets the capture overflow flag.
- R6: A playback write into a full playback queue with no pop in the same cycle is discarded, leaving the contents unchanged, and sets the playback overflow flag.
- R7: A pop from an empty queue returns all-zero read data and sets that queue's underflow flag. This applies to the capture pop by software and to the playback pull by the serializer.
- R8: The overflow and underflow flags are sticky. Each one is cleared by a one on its bit of the 4-bit clear strobe: bit 0 clears capture underflow, bit 1 capture overflow, bit 2 playback underflow, bit 3 playback overflow. If a flag is set and cleared in the same cycle, the set wins.
- R9: A flush strobe empties its queue on the next edge, returning the count to 0. Any push or pop on that queue in the same cycle is ignored and sets no flag. The flush strobe is a pulse with no stored state.
- R10: Interrupt enable bits are assigned as follows: bit 0 capture threshold, bit 1 capture overflow, bit 2 capture underflow, bit 3 playback threshold, bit 4 playback overflow, bit 5 playback underflow. The capture summary is the OR of enabled bits 0 to 2, the playback summary is the OR of enabled bits 3 to 5, and the combined line is the OR of both summaries.
- R11: A push and a pop in the same cycle on a non-empty queue both take effect, even when the queue is full. The count is unchanged and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pb_wr_en | input | 1 | Processor push into playback queue |
| pb_wr_data | input | 32 | Playback word to push |
| pb_rd_en | input | 1 | Serializer pull from playback queue |
| pb_rd_data | output | 32 | Playback head word, zero when empty |
| pb_flush | input | 1 | Flush strobe for playback queue |
| pb_thresh | input | 4 | Playback threshold value |
| cap_wr_en | input | 1 | Deserializer push into capture queue |
| cap_wr_data | input | 32 | Capture word to push |
| cap_rd_en | input | 1 | Processor pop from capture queue |
| cap_rd_data | output | 32 | Capture head word, zero when empty |
| cap_flush | input | 1 | Flush strobe for capture queue |
| cap_thresh | input | 4 | Capture threshold code (level minus one) |
| err_clr | input | 4 | Write-one clear strobes for sticky flags |
| irq_en | input | 6 | Per-source interrupt enables |
| pb_level | output | 4 | Playback count, low 4 bits |
| pb_full | output | 1 | Playback queue holds 16 words |
| pb_empty | output | 1 | Playback queue holds no words |
| pb_thr | output | 1 | Playback threshold flag |
| pb_ovf | output | 1 | Sticky playback overflow |
| pb_udf | output | 1 | Sticky playback underflow |
| cap_level | output | 4 | Capture count, low 4 bits |
| cap_full | output | 1 | Capture queue holds 16 words |
| cap_empty | output | 1 | Capture queue holds no words |
| cap_thr | output | 1 | Capture threshold flag |
| cap_ovf | output | 1 | Sticky capture overflow |
| cap_udf | output | 1 | Sticky capture underflow |
| cap_irq | output | 1 | Capture interrupt summary |
| pb_irq | output | 1 | Playback interrupt summary |
| any_irq | output | 1 | Combined interrupt line |

## Verification
Directed sequences fill each queue to 16 words and keep writing. This separates the playback queue, which discards the extra words, from the capture queue, which overwrites its oldest words, and it shows the level reading 0 when the queue is full. Further directed cases drain each queue past empty, set and clear flags in the same cycle, flush while a push is pending, and sweep the thresholds across their end codes. Biased random traffic then mixes pushes, pops, flushes, clears and enable changes, so that simultaneous push and pop is exercised at the full and empty edges. A bench-side queue model predicts every output after each edge.

// File: rtl/afq_pkg.sv
package afq_pkg;
    localparam int AFQ_DATA_W = 32;
    localparam int AFQ_DEPTH  = 16;

    // interrupt enable / source positions
    localparam int IRQ_CAP_THR = 0;
    localparam int IRQ_CAP_OVF = 1;
    localparam int IRQ_CAP_UDF = 2;
    localparam int IRQ_PB_THR  = 3;
    localparam int IRQ_PB_OVF  = 4;
    localparam int IRQ_PB_UDF  = 5;
    localparam int IRQ_NUM     = 6;

    // clear strobe positions
    localparam int CLR_CAP_UDF = 0;
    localparam int CLR_CAP_OVF = 1;
    localparam int CLR_PB_UDF  = 2;
    localparam int CLR_PB_OVF  = 3;
    localparam int CLR_NUM     = 4;
endpackage

// File: rtl/afq_fifo.sv
module afq_fifo #(
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 16,
    parameter bit OVERWRITE = 1'b0,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    input  logic              clr_ovf,
    input  logic              clr_udf,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              udf
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             udf;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic mem_we;
    logic pop_ok, push_ok, is_full, ovw;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_full = (st_q.cnt == CNT_W'(DEPTH));
    assign pop_ok  = pop && (st_q.cnt != '0);
    assign push_ok = push && (!is_full || pop_ok);

    generate
        if (OVERWRITE) begin : g_ovw
            assign ovw = push && is_full && !pop_ok;
        end else begin : g_drop
            assign ovw = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.cnt    = '0;
            st_d.ovf    = st_q.ovf & ~clr_ovf;
            st_d.udf    = st_q.udf & ~clr_udf;
        end else begin
            if (pop_ok || ovw) begin
                st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            end
            if (push_ok || ovw) begin
                mem_we      = 1'b1;
                st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
            end
            if (push_ok && !pop_ok) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (pop_ok && !push_ok) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            st_d.ovf = (push && !push_ok) | (st_q.ovf & ~clr_ovf);
            st_d.udf = (pop && !pop_ok) | (st_q.udf & ~clr_udf);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem_q[st_q.wr_ptr] <= push_data;
        end
    end

    assign pop_data = (st_q.cnt == '0) ? '0 : mem_q[st_q.rd_ptr];
    assign count    = st_q.cnt;
    assign ovf      = st_q.ovf;
    assign udf      = st_q.udf;
endmodule

// File: rtl/afq_level_flags.sv
module afq_level_flags #(
    parameter int DEPTH     = 16,
    parameter bit AT_LEAST  = 1'b0,
    localparam int LVL_W    = $clog2(DEPTH),
    localparam int CNT_W    = LVL_W + 1
) (
    input  logic [CNT_W-1:0] count,
    input  logic [LVL_W-1:0] thresh,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             thr
);
    assign level = count[LVL_W-1:0];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    generate
        if (AT_LEAST) begin : g_ge
            // code n means n+1 words
            assign thr = (count >= ({1'b0, thresh} + 1'b1));
        end else begin : g_le
            assign thr = (count <= {1'b0, thresh});
        end
    endgenerate
endmodule

// File: rtl/afq_irq_merge.sv
module afq_irq_merge
    import afq_pkg::*;
(
    input  logic [IRQ_NUM-1:0] src,
    input  logic [IRQ_NUM-1:0] en,
    output logic               cap_irq,
    output logic               pb_irq,
    output logic               any_irq
);
    logic [IRQ_NUM-1:0] gated;
    assign gated   = src & en;
    assign cap_irq = gated[IRQ_CAP_THR] | gated[IRQ_CAP_OVF] | gated[IRQ_CAP_UDF];
    assign pb_irq  = gated[IRQ_PB_THR]  | gated[IRQ_PB_OVF]  | gated[IRQ_PB_UDF];
    assign any_irq = cap_irq | pb_irq;
endmodule

// File: rtl/audio_fifo_flags.sv
module audio_fifo_flags
    import afq_pkg::*;
#(
    parameter int DATA_W = AFQ_DATA_W,
    parameter int DEPTH  = AFQ_DEPTH,
    localparam int LVL_W = $clog2(DEPTH),
    localparam int CNT_W = LVL_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pb_wr_en,
    input  logic [DATA_W-1:0]  pb_wr_data,
    input  logic               pb_rd_en,
    output logic [DATA_W-1:0]  pb_rd_data,
    input  logic               pb_flush,
    input  logic [LVL_W-1:0]   pb_thresh,
    input  logic               cap_wr_en,
    input  logic [DATA_W-1:0]  cap_wr_data,
    input  logic               cap_rd_en,
    output logic [DATA_W-1:0]  cap_rd_data,
    input  logic               cap_flush,
    input  logic [LVL_W-1:0]   cap_thresh,
    input  logic [CLR_NUM-1:0] err_clr,
    input  logic [IRQ_NUM-1:0] irq_en,
    output logic [LVL_W-1:0]   pb_level,
    output logic               pb_full,
    output logic               pb_empty,
    output logic               pb_thr,
    output logic               pb_ovf,
    output logic               pb_udf,
    output logic [LVL_W-1:0]   cap_level,
    output logic               cap_full,
    output logic               cap_empty,
    output logic               cap_thr,
    output logic               cap_ovf,
    output logic               cap_udf,
    output logic               cap_irq,
    output logic               pb_irq,
    output logic               any_irq
);
    logic [CNT_W-1:0]   pb_cnt, cap_cnt;
    logic [IRQ_NUM-1:0] irq_src;

    afq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OVERWRITE(1'b0)) u_pb_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (pb_wr_en),
        .push_data (pb_wr_data),
        .pop       (pb_rd_en),
        .flush     (pb_flush),
        .clr_ovf   (err_clr[CLR_PB_OVF]),
        .clr_udf   (err_clr[CLR_PB_UDF]),
        .pop_data  (pb_rd_data),
        .count     (pb_cnt),
        .ovf       (pb_ovf),
        .udf       (pb_udf)
    );

    afq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OVERWRITE(1'b1)) u_cap_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cap_wr_en),
        .push_data (cap_wr_data),
        .pop       (cap_rd_en),
        .flush     (cap_flush),
        .clr_ovf   (err_clr[CLR_CAP_OVF]),
        .clr_udf   (err_clr[CLR_CAP_UDF]),
        .pop_data  (cap_rd_data),
        .count     (cap_cnt),
        .ovf       (cap_ovf),
        .udf       (cap_udf)
    );

    afq_level_flags #(.DEPTH(DEPTH), .AT_LEAST(1'b0)) u_pb_lvl (
        .count  (pb_cnt),
        .thresh (pb_thresh),
        .level  (pb_level),
        .full   (pb_full),
        .empty  (pb_empty),
        .thr    (pb_thr)
    );

    afq_level_flags #(.DEPTH(DEPTH), .AT_LEAST(1'b1)) u_cap_lvl (
        .count  (cap_cnt),
        .thresh (cap_thresh),
        .level  (cap_level),
        .full   (cap_full),
        .empty  (cap_empty),
        .thr    (cap_thr)
    );

    always_comb begin
        irq_src              = '0;
        irq_src[IRQ_CAP_THR] = cap_thr;
        irq_src[IRQ_CAP_OVF] = cap_ovf;
        irq_src[IRQ_CAP_UDF] = cap_udf;
        irq_src[IRQ_PB_THR]  = pb_thr;
        irq_src[IRQ_PB_OVF]  = pb_ovf;
        irq_src[IRQ_PB_UDF]  = pb_udf;
    end

    afq_irq_merge u_irq (
        .src     (irq_src),
        .en      (irq_en),
        .cap_irq (cap_irq),
        .pb_irq  (pb_irq),
        .any_irq (any_irq)
    );
endmodule

// File: rtl/afq_checker.sv
module afq_checker #(
    parameter int DATA_W = 32,
    parameter int LVL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pb_wr_en,
    input logic              pb_rd_en,
    input logic              pb_flush,
    input logic              cap_wr_en,
    input logic              cap_rd_en,
    input logic              cap_flush,
    input logic [3:0]        err_clr,
    input logic [DATA_W-1:0] cap_rd_data,
    input logic [LVL_W-1:0]  pb_level,
    input logic              pb_full,
    input logic              pb_empty,
    input logic              pb_ovf,
    input logic [LVL_W-1:0]  cap_level,
    input logic              cap_full,
    input logic              cap_empty,
    input logic              cap_ovf,
    input logic              cap_udf
);
    AST_FULL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_full || cap_full) |-> ((!pb_full || pb_level == '0) && (!cap_full || cap_level == '0))); // R2
    AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(pb_full && pb_empty) && !(cap_full && cap_empty)); // R1
    AST_CAP_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_wr_en && cap_full && !cap_rd_en && !cap_flush) |=> (cap_full && cap_ovf)); // R5
    AST_PB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_wr_en && pb_full && !pb_rd_en && !pb_flush) |=> (pb_full && pb_ovf)); // R6
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_empty && cap_rd_en) |-> (cap_rd_data == '0)); // R7
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_udf && !err_clr[0]) |=> cap_udf); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_ovf && !err_clr[3]) |=> pb_ovf); // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_flush && cap_flush) |=> (pb_empty && cap_empty)); // R9
    AST_PUSH_POP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_full && pb_wr_en && pb_rd_en && !pb_flush && !pb_ovf && !$isunknown(pb_level)) |=> (pb_full && !pb_ovf)); // R11
endmodule

bind audio_fifo_flags afq_checker #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pb_wr_en    (pb_wr_en),
    .pb_rd_en    (pb_rd_en),
    .pb_flush    (pb_flush),
    .cap_wr_en   (cap_wr_en),
    .cap_rd_en   (cap_rd_en),
    .cap_flush   (cap_flush),
    .err_clr     (err_clr),
    .cap_rd_data (cap_rd_data),
    .pb_level    (pb_level),
    .pb_full     (pb_full),
    .pb_empty    (pb_empty),
    .pb_ovf      (pb_ovf),
    .cap_level   (cap_level),
    .cap_full    (cap_full),
    .cap_empty   (cap_empty),
    .cap_ovf     (cap_ovf),
    .cap_udf     (cap_udf)
);

// File: tb/audio_fifo_flags_tb.sv
module audio_fifo_flags_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        pb_wr_en = 0, pb_rd_en = 0, pb_flush = 0;
    logic [31:0] pb_wr_data = 0;
    logic [3:0]  pb_thresh = 0;
    logic        cap_wr_en = 0, cap_rd_en = 0, cap_flush = 0;
    logic [31:0] cap_wr_data = 0;
    logic [3:0]  cap_thresh = 0;
    logic [3:0]  err_clr = 0;
    logic [5:0]  irq_en = 0;
    logic [31:0] pb_rd_data, cap_rd_data;
    logic [3:0]  pb_level, cap_level;
    logic pb_full, pb_empty, pb_thr, pb_ovf, pb_udf;
    logic cap_full, cap_empty, cap_thr, cap_ovf, cap_udf;
    logic cap_irq, pb_irq, any_irq;

    audio_fifo_flags u_dut (.*);

    int checks = 0, fails = 0;
    logic [31:0] pbq[$], capq[$];
    logic m_pb_ovf, m_pb_udf, m_cap_ovf, m_cap_udf;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic lvl_le(input int n, input logic [3:0] t); return n <= int'(t); endfunction
    function automatic logic lvl_ge(input int n, input logic [3:0] t); return n >= int'(t) + 1; endfunction

    // compare every output against the model (called at negedge)
    task automatic check_all(input string tag);
        logic pt, ct, ci, pi;
        pt = lvl_le(pbq.size(), pb_thresh);
        ct = lvl_ge(capq.size(), cap_thresh);
        ci = (ct & irq_en[0]) | (m_cap_ovf & irq_en[1]) | (m_cap_udf & irq_en[2]);
        pi = (pt & irq_en[3]) | (m_pb_ovf & irq_en[4]) | (m_pb_udf & irq_en[5]);
        chk({"R2 ", tag}, "pb_level", 32'(pb_level), 32'(pbq.size() % 16));
        chk({"R1 ", tag}, "pb_full", 32'(pb_full), 32'(pbq.size() == 16));
        chk({"R1 ", tag}, "pb_empty", 32'(pb_empty), 32'(pbq.size() == 0));
        chk({"R3 ", tag}, "pb_thr", 32'(pb_thr), 32'(pt));
        chk({"R6 ", tag}, "pb_ovf", 32'(pb_ovf), 32'(m_pb_ovf));
        chk({"R7 ", tag}, "pb_udf", 32'(pb_udf), 32'(m_pb_udf));
        chk({"R2 ", tag}, "cap_level", 32'(cap_level), 32'(capq.size() % 16));
        chk({"R1 ", tag}, "cap_full", 32'(cap_full), 32'(capq.size() == 16));
        chk({"R1 ", tag}, "cap_empty", 32'(cap_empty), 32'(capq.size() == 0));
        chk({"R4 ", tag}, "cap_thr", 32'(cap_thr), 32'(ct));
        chk({"R5 ", tag}, "cap_ovf", 32'(cap_ovf), 32'(m_cap_ovf));
        chk({"R7 ", tag}, "cap_udf", 32'(cap_udf), 32'(m_cap_udf));
        chk({"R10 ", tag}, "cap_irq", 32'(cap_irq), 32'(ci));
        chk({"R10 ", tag}, "pb_irq", 32'(pb_irq), 32'(pi));
        chk({"R10 ", tag}, "any_irq", 32'(any_irq), 32'(ci | pi));
    endtask

    // one cycle: inputs already set; check read data, clock, update model, check outputs
    task automatic step(input string tag);
        logic pop_ok, push_ok, so, su;
        #1;
        if (pb_rd_en)  chk({"R1 R7 ", tag}, "pb_rd_data", pb_rd_data, pbq.size() ? pbq[0] : 32'h0);
        if (cap_rd_en) chk({"R1 R7 ", tag}, "cap_rd_data", cap_rd_data, capq.size() ? capq[0] : 32'h0);
        @(posedge clk);
        // playback model
        so = 0; su = 0;
        if (pb_flush) pbq.delete();
        else begin
            pop_ok  = pb_rd_en && pbq.size() > 0;
            push_ok = pb_wr_en && (pbq.size() < 16 || pop_ok);
            su = pb_rd_en && !pop_ok;
            so = pb_wr_en && !push_ok;
            if (pop_ok)  void'(pbq.pop_front());
            if (push_ok) pbq.push_back(pb_wr_data);
        end
        m_pb_ovf = so | (m_pb_ovf & ~err_clr[3]);
        m_pb_udf = su | (m_pb_udf & ~err_clr[2]);
        // capture model
        so = 0; su = 0;
        if (cap_flush) capq.delete();
        else begin
            pop_ok = cap_rd_en && capq.size() > 0;
            su = cap_rd_en && !pop_ok;
            if (pop_ok) void'(capq.pop_front());
            if (cap_wr_en) begin
                if (capq.size() == 16) begin
                    void'(capq.pop_front());  // R5 overwrite oldest
                    so = 1;
                end
                capq.push_back(cap_wr_data);
            end
        end
        m_cap_ovf = so | (m_cap_ovf & ~err_clr[1]);
        m_cap_udf = su | (m_cap_udf & ~err_clr[0]);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle();
        pb_wr_en = 0; pb_rd_en = 0; pb_flush = 0;
        cap_wr_en = 0; cap_rd_en = 0; cap_flush = 0; err_clr = 0;
    endtask

    initial begin : watchdog
        #1500000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_pb_ovf = 0; m_pb_udf = 0; m_cap_ovf = 0; m_cap_udf = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_all("reset");   // R1 R2 reset state
        rst_n = 1'b1;
        @(negedge clk);
        irq_en = 6'h3F;
        pb_thresh = 4'd3; cap_thresh = 4'd0;

        // R1 R6: fill playback past capacity
        for (int i = 0; i < 18; i++) begin
            idle(); pb_wr_en = 1; pb_wr_data = 32'hA000_0000 + i;
            step("pb fill R6");
        end
        // R11: push and pop while full
        idle(); pb_wr_en = 1; pb_rd_en = 1; pb_wr_data = 32'hBEEF0001; err_clr[3] = 1;
        step("pb full push+pop R11");
        // R8: set and clear same cycle, set wins
        idle(); pb_wr_en = 1; pb_wr_data = 32'h1; err_clr[3] = 1;
        step("pb set vs clr R8");
        // R1 R7: drain past empty
        for (int i = 0; i < 18; i++) begin
            idle(); pb_rd_en = 1;
            step("pb drain R7");
        end
        idle(); err_clr = 4'hF;
        step("clear all R8");

        // R4 R5: capture fill with overwrite, threshold at 16 words
        cap_thresh = 4'd15;
        for (int i = 0; i < 20; i++) begin
            idle(); cap_wr_en = 1; cap_wr_data = 32'hC000_0000 + i;
            step("cap fill R5 R4");
        end
        // R9: flush with simultaneous push, no flag
        idle(); cap_flush = 1; cap_wr_en = 1; cap_wr_data = 32'h77; err_clr[1] = 1;
        step("cap flush R9");
        idle(); cap_rd_en = 1;
        step("cap empty read R7");
        // threshold sweep R3 R4
        for (int t = 0; t < 16; t++) begin
            idle(); pb_thresh = 4'(t); cap_thresh = 4'(t);
            pb_wr_en = 1; pb_wr_data = 32'(t); cap_wr_en = 1; cap_wr_data = 32'(t * 3);
            step("thr sweep R3 R4");
        end
        idle(); pb_flush = 1; cap_flush = 1; err_clr = 4'hF;
        step("flush both R9");

        // random traffic R1..R11
        for (int n = 0; n < 4000; n++) begin
            idle();
            pb_wr_en    = ($urandom % 100) < 55;
            pb_rd_en    = ($urandom % 100) < 45;
            pb_wr_data  = $urandom;
            cap_wr_en   = ($urandom % 100) < 55;
            cap_rd_en   = ($urandom % 100) < 45;
            cap_wr_data = $urandom;
            pb_flush    = ($urandom % 100) < 2;
            cap_flush   = ($urandom % 100) < 2;
            err_clr     = (($urandom % 100) < 8) ? 4'($urandom) : 4'h0;
            if (($urandom % 50) == 0) irq_en = 6'($urandom);
            if (($urandom % 40) == 0) begin
                pb_thresh = 4'($urandom); cap_thresh = 4'($urandom);
            end
            step("random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule